// File: doc/BRIEF.md
# Redundant Store Verification Buffer

This block holds back every store made by a pair of redundantly executing threads until both copies agree. The leading thread deposits each store (address and data) into a circular buffer. Later, the trailing thread presents its own copy of the same store. The block compares that copy against the oldest entry that has not yet been verified. When both address and data agree, the entry is marked verified. Verified entries leave for memory in program order over a valid/ready handshake.

Any disagreement is treated as a detected fault. So is a trailing store that has no leading counterpart waiting. After a fault, the block raises a sticky fault flag and stops releasing stores, so nothing corrupted leaves the protected region. When the buffer is full, the leading thread is told to stall. The nominal depth is 64 entries, and the depth is a parameter that must be a power of two.

Top module: `store_verify_buffer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `fault`, `mem_valid` and `lead_stall` are all 0 and the buffer holds no entries.
- R2: A leading store offered while `lead_stall` is low is appended at the young end of the buffer. `lead_stall` is high exactly when the buffer holds DEPTH entries. A leading store offered while `lead_stall` is high is dropped and never reaches memory.
- R3: A trailing store is compared, in both address and data, with the oldest entry that is not yet verified. When both fields agree, that entry becomes verified, and trailing stores therefore verify entries in program order.
- R4: `mem_valid` is high only while the oldest buffered entry is verified and no fault is held. `mem_addr` and `mem_data` then carry that entry, so stores reach memory in the order the leading thread issued them.
- R5: An entry leaves the buffer only in a cycle where `mem_valid` and `mem_ready` are both high. While `mem_valid` is high and `mem_ready` is low, `mem_addr` and `mem_data` stay unchanged in the following cycle unless a fault is raised.
- R6: A trailing store whose address or data differs from the oldest unverified entry sets `fault` from the next cycle.
- R7: A trailing store that arrives when no unverified entry existed at the start of its cycle sets `fault` from the next cycle. This includes the case where a leading store is written in that same cycle.
- R8: Once set, `fault` stays high until `rst`. While `fault` is high, `mem_valid` is 0 and trailing stores have no effect.
- R9: A leading write, a trailing verification and a memory commit may all take effect in one cycle. `lead_stall` is derived from the occupancy at the start of the cycle, so a full buffer refuses a leading store even in a cycle that commits an entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lead_valid | input | 1 | Leading thread offers a store |
| lead_addr | input | 32 | Leading store address |
| lead_data | input | 32 | Leading store data |
| lead_stall | output | 1 | Buffer full; the leading store is not taken |
| trail_valid | input | 1 | Trailing thread presents a store for checking |
| trail_addr | input | 32 | Trailing store address |
| trail_data | input | 32 | Trailing store data |
| mem_valid | output | 1 | Verified store offered to memory |
| mem_ready | input | 1 | Memory accepts the offered store |
| mem_addr | output | 32 | Address of the offered store |
| mem_data | output | 32 | Data of the offered store |
| fault | output | 1 | Sticky fault indication |

## Verification
The two functions that can fall in one cycle are the trailing-side verification of the oldest unverified entry and the memory-side commit of the oldest verified entry. The leading append can join them in the same cycle. The bench provokes this with a pseudo-random phase that drives leading stores, in-order trailing copies and a toggling `mem_ready` together, and with a directed cycle that asserts all three at once on a partly filled buffer. A behavioural queue model in the bench recomputes the outputs after every edge and judges them. The full-buffer case, where a commit and a refused leading store coincide, is forced separately.

// File: rtl/svb_pkg.sv
package svb_pkg;

    parameter int unsigned SVB_ADDR_W = 32;
    parameter int unsigned SVB_DATA_W = 32;

    typedef struct packed {
        logic [SVB_ADDR_W-1:0] addr;
        logic [SVB_DATA_W-1:0] data;
    } svb_store_t;

    typedef enum logic [1:0] {
        CMP_IDLE     = 2'd0,
        CMP_MATCH    = 2'd1,
        CMP_MISMATCH = 2'd2,
        CMP_ORPHAN   = 2'd3
    } svb_cmp_e;

    function automatic svb_store_t svb_pack(input logic [SVB_ADDR_W-1:0] a,
                                            input logic [SVB_DATA_W-1:0] d);
        svb_store_t s;
        s.addr = a;
        s.data = d;
        return s;
    endfunction

    function automatic logic svb_is_fault(input svb_cmp_e r);
        return (r == CMP_MISMATCH) || (r == CMP_ORPHAN);
    endfunction

endpackage

// File: rtl/svb_entry_ram.sv
module svb_entry_ram
    import svb_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  svb_store_t       wdata,
    input  logic [IDX_W-1:0] commit_idx,
    output svb_store_t       commit_entry,
    input  logic [IDX_W-1:0] check_idx,
    output svb_store_t       check_entry
);

    svb_store_t slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            slots[waddr] <= wdata;
        end
    end

    assign commit_entry = slots[commit_idx];
    assign check_entry  = slots[check_idx];

endmodule

// File: rtl/svb_ptr_ctrl.sv
module svb_ptr_ctrl #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             verify,
    input  logic             pop,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] ver_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic             full,
    output logic             has_verified,
    output logic             has_unverified
);

    localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] ONE      = PTR_W'(1);

    logic [PTR_W-1:0] head_q, ver_q, tail_q;
    logic [PTR_W-1:0] occupancy;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            ver_q  <= '0;
            tail_q <= '0;
        end else begin
            if (push)   tail_q <= tail_q + ONE;
            if (verify) ver_q  <= ver_q + ONE;
            if (pop)    head_q <= head_q + ONE;
        end
    end

    assign occupancy      = tail_q - head_q;
    assign full           = (occupancy == FULL_CNT);
    assign has_verified   = (ver_q != head_q);
    assign has_unverified = (tail_q != ver_q);
    assign head_idx       = head_q[IDX_W-1:0];
    assign ver_idx        = ver_q[IDX_W-1:0];
    assign tail_idx       = tail_q[IDX_W-1:0];

endmodule

// File: rtl/svb_compare.sv
module svb_compare
    import svb_pkg::*;
(
    input  logic       enable,
    input  logic       has_unverified,
    input  svb_store_t trail_store,
    input  svb_store_t lead_store,
    output svb_cmp_e   result
);

    logic addr_eq, data_eq;

    assign addr_eq = (trail_store.addr == lead_store.addr);
    assign data_eq = (trail_store.data == lead_store.data);

    always_comb begin
        result = CMP_IDLE;
        if (enable) begin
            if (!has_unverified)       result = CMP_ORPHAN;
            else if (addr_eq && data_eq) result = CMP_MATCH;
            else                       result = CMP_MISMATCH;
        end
    end

endmodule

// File: rtl/store_verify_buffer.sv
module store_verify_buffer
    import svb_pkg::*;
#(
    parameter int unsigned DEPTH = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  lead_valid,
    input  logic [SVB_ADDR_W-1:0] lead_addr,
    input  logic [SVB_DATA_W-1:0] lead_data,
    output logic                  lead_stall,
    input  logic                  trail_valid,
    input  logic [SVB_ADDR_W-1:0] trail_addr,
    input  logic [SVB_DATA_W-1:0] trail_data,
    output logic                  mem_valid,
    input  logic                  mem_ready,
    output logic [SVB_ADDR_W-1:0] mem_addr,
    output logic [SVB_DATA_W-1:0] mem_data,
    output logic                  fault
);

    localparam int unsigned IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0] head_idx, ver_idx, tail_idx;
    logic             full, has_verified, has_unverified;
    logic             push, verify, pop;
    logic             fault_q;
    svb_store_t       commit_entry, check_entry;
    svb_cmp_e         cmp_res;

    assign push      = lead_valid && !full;
    assign mem_valid = has_verified && !fault_q;
    assign pop       = mem_valid && mem_ready;
    assign verify    = (cmp_res == CMP_MATCH);

    svb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptrs (
        .clk            (clk),
        .rst            (rst),
        .push           (push),
        .verify         (verify),
        .pop            (pop),
        .head_idx       (head_idx),
        .ver_idx        (ver_idx),
        .tail_idx       (tail_idx),
        .full           (full),
        .has_verified   (has_verified),
        .has_unverified (has_unverified)
    );

    svb_entry_ram #(.DEPTH(DEPTH)) u_ram (
        .clk          (clk),
        .we           (push),
        .waddr        (tail_idx),
        .wdata        (svb_pack(lead_addr, lead_data)),
        .commit_idx   (head_idx),
        .commit_entry (commit_entry),
        .check_idx    (ver_idx),
        .check_entry  (check_entry)
    );

    svb_compare u_cmp (
        .enable         (trail_valid && !fault_q),
        .has_unverified (has_unverified),
        .trail_store    (svb_pack(trail_addr, trail_data)),
        .lead_store     (check_entry),
        .result         (cmp_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b0;
        end else if (svb_is_fault(cmp_res)) begin
            fault_q <= 1'b1;
        end
    end

    assign lead_stall = full;
    assign mem_addr   = commit_entry.addr;
    assign mem_data   = commit_entry.data;
    assign fault      = fault_q;

endmodule

// File: rtl/svb_checker.sv
module svb_checker
    import svb_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  lead_valid,
    input logic                  lead_stall,
    input logic                  mem_valid,
    input logic                  mem_ready,
    input logic [SVB_ADDR_W-1:0] mem_addr,
    input logic [SVB_DATA_W-1:0] mem_data,
    input logic                  fault
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEPTH);

    logic [CNT_W-1:0] occ;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= '0;
        end else begin
            occ <= occ + CNT_W'(lead_valid && !lead_stall) - CNT_W'(mem_valid && mem_ready);
        end
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!fault && !mem_valid && !lead_stall));

    // R2
    a_r2_stall_full: assert property (@(posedge clk) disable iff (rst)
        lead_stall == (occ == LIMIT));

    // R4
    a_r4_valid_needs_entry: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (occ != '0));

    // R5
    a_r5_hold_offer: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=>
            (fault || (mem_valid && $stable(mem_addr) && $stable(mem_data))));

    // R8
    a_r8_fault_sticky: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

endmodule

bind store_verify_buffer svb_checker #(.DEPTH(DEPTH)) u_svb_checker (
    .clk        (clk),
    .rst        (rst),
    .lead_valid (lead_valid),
    .lead_stall (lead_stall),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .fault      (fault)
);

// File: tb/store_verify_buffer_test.sv
module store_verify_buffer_test;
    import svb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int AW         = SVB_ADDR_W;
    localparam int DW         = SVB_DATA_W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lead_valid = 1'b0, trail_valid = 1'b0, mem_ready = 1'b0;
    logic [AW-1:0] lead_addr = '0, trail_addr = '0;
    logic [DW-1:0] lead_data = '0, trail_data = '0;
    logic          lead_stall, mem_valid, fault;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;

    store_verify_buffer #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst),
        .lead_valid(lead_valid), .lead_addr(lead_addr), .lead_data(lead_data),
        .lead_stall(lead_stall),
        .trail_valid(trail_valid), .trail_addr(trail_addr), .trail_data(trail_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data), .fault(fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    svb_store_t mq[$];
    int         mver = 0;
    bit         mfault = 1'b0;
    svb_store_t prog[$];
    int         tidx = 0;
    int         checks = 0, fails = 0, cycles = 0;
    bit         done = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            mver   = 0;
            mfault = 1'b0;
        end else begin
            bit ev, commit, tmatch, tfail, accept;
            ev     = !mfault && (mver > 0);
            commit = ev && mem_ready;
            accept = lead_valid && (mq.size() < DEPTH);
            tmatch = 1'b0;
            tfail  = 1'b0;
            if (trail_valid && !mfault) begin
                if (mver >= mq.size()) tfail = 1'b1;
                else if (mq[mver].addr == trail_addr && mq[mver].data == trail_data) tmatch = 1'b1;
                else tfail = 1'b1;
            end
            if (tmatch) mver++;
            if (tfail) mfault = 1'b1;
            if (commit) begin
                void'(mq.pop_front());
                mver--;
            end
            if (accept) mq.push_back(svb_pack(lead_addr, lead_data));
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit ev;
            ev = !mfault && (mver > 0);
            check("R2", "lead_stall", 64'(lead_stall), 64'(mq.size() == DEPTH));
            check("R4", "mem_valid", 64'(mem_valid), 64'(ev));
            check("R8", "fault", 64'(fault), 64'(mfault));
            if (ev) begin
                check("R4", "mem_addr", 64'(mem_addr), 64'(mq[0].addr));
                check("R4", "mem_data", 64'(mem_data), 64'(mq[0].data));
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [AW-1:0] mk_addr(input int i);
        return AW'(32'h0000_4000 + i * 4);
    endfunction
    function automatic logic [DW-1:0] mk_data(input int i);
        return DW'(32'h9E37_79B9 * (i + 1) ^ 32'h5A5A_0000);
    endfunction

    // one cycle: inputs applied at a negedge, held over the next posedge
    task automatic step(input logic lv, input int li, input logic tv, input logic rdy);
        lead_valid  = lv;
        lead_addr   = mk_addr(li);
        lead_data   = mk_data(li);
        if (lv && mq.size() < DEPTH) prog.push_back(svb_pack(mk_addr(li), mk_data(li)));
        trail_valid = tv;
        if (tv && tidx < prog.size()) begin
            trail_addr = prog[tidx].addr;
            trail_data = prog[tidx].data;
            tidx++;
        end
        mem_ready = rdy;
        @(negedge clk);
    endtask

    task automatic idle(input logic rdy);
        step(1'b0, 0, 1'b0, rdy);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        lead_valid = 1'b0; trail_valid = 1'b0; mem_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        prog.delete();
        tidx = 0;
        @(negedge clk);
    endtask

    initial begin
        logic [AW-1:0] held_a;
        logic [15:0]   lfsr;
        int            k;

        // R1 reset state
        @(negedge clk); @(negedge clk);
        check("R1", "fault in reset", 64'(fault), 64'd0);
        check("R1", "mem_valid in reset", 64'(mem_valid), 64'd0);
        check("R1", "lead_stall in reset", 64'(lead_stall), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "mem_valid after reset", 64'(mem_valid), 64'd0);

        // R3/R4: three stores, none leaves before verification
        for (int i = 0; i < 3; i++) step(1'b1, i, 1'b0, 1'b1);
        idle(1'b1);
        check("R4", "unverified store held", 64'(mem_valid), 64'd0);
        step(1'b0, 0, 1'b1, 1'b0);
        check("R3", "first verified offered", 64'(mem_valid), 64'd1);
        check("R3", "first address", 64'(mem_addr), 64'(mk_addr(0)));
        step(1'b0, 0, 1'b1, 1'b1);
        step(1'b0, 0, 1'b1, 1'b1);
        idle(1'b1); idle(1'b1);
        check("R4", "drained", 64'(mem_valid), 64'd0);

        // R2 fill to full, extra store dropped
        for (int i = 10; i < 10 + DEPTH; i++) step(1'b1, i, 1'b0, 1'b0);
        check("R2", "stall at full", 64'(lead_stall), 64'd1);
        step(1'b1, 99, 1'b0, 1'b0);
        check("R2", "still full after refused store", 64'(lead_stall), 64'd1);
        // R5 hold while not ready
        step(1'b0, 0, 1'b1, 1'b0);
        held_a = mem_addr;
        for (int i = 0; i < 4; i++) begin
            idle(1'b0);
            check("R5", "address held", 64'(mem_addr), 64'(held_a));
        end
        // R9 full buffer: commit and refused lead in one cycle
        step(1'b1, 98, 1'b0, 1'b1);
        check("R9", "one slot freed, refused store not written", 64'(lead_stall), 64'd0);
        // R9 lead + trail + commit together
        step(1'b0, 0, 1'b1, 1'b0);
        step(1'b1, 40, 1'b1, 1'b1);
        check("R9", "concurrent cycle keeps order", 64'(mem_addr), 64'(mk_addr(12)));
        while (tidx < prog.size()) step(1'b0, 0, 1'b1, 1'b1);
        for (int i = 0; i < DEPTH + 2; i++) idle(1'b1);
        check("R2", "dropped store never committed", 64'(mem_valid), 64'd0);

        // random mixed traffic
        lfsr = 16'hACE1;
        k = 200;
        for (int c = 0; c < 400; c++) begin
            logic tv;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tv = lfsr[1] && (tidx < prog.size());
            step(lfsr[0], k, tv, lfsr[2] | lfsr[3]);
            k++;
        end
        while (tidx < prog.size()) step(1'b0, 0, 1'b1, 1'b1);
        for (int i = 0; i < DEPTH + 2; i++) idle(1'b1);

        // R6 address mismatch
        do_reset();
        step(1'b1, 1, 1'b0, 1'b1);
        step(1'b1, 2, 1'b0, 1'b1);
        trail_addr = mk_addr(7); trail_data = mk_data(1);
        lead_valid = 1'b0; trail_valid = 1'b1; mem_ready = 1'b1;
        @(negedge clk);
        check("R6", "address mismatch", 64'(fault), 64'd1);
        check("R8", "no commit under fault", 64'(mem_valid), 64'd0);
        trail_addr = mk_addr(1);
        @(negedge clk);
        trail_valid = 1'b0;
        check("R8", "fault sticky", 64'(fault), 64'd1);
        idle(1'b1);

        // R6 data mismatch
        do_reset();
        step(1'b1, 3, 1'b0, 1'b1);
        trail_addr = mk_addr(3); trail_data = mk_data(3) ^ 32'h1;
        trail_valid = 1'b1; lead_valid = 1'b0;
        @(negedge clk);
        trail_valid = 1'b0;
        check("R6", "data mismatch", 64'(fault), 64'd1);
        idle(1'b1);

        // R7 orphan on empty buffer
        do_reset();
        trail_addr = mk_addr(5); trail_data = mk_data(5); trail_valid = 1'b1;
        @(negedge clk);
        trail_valid = 1'b0;
        check("R7", "orphan trailing store", 64'(fault), 64'd1);

        // R7 orphan with same-cycle leading write
        do_reset();
        lead_valid = 1'b1; lead_addr = mk_addr(6); lead_data = mk_data(6);
        trail_valid = 1'b1; trail_addr = mk_addr(6); trail_data = mk_data(6);
        @(negedge clk);
        lead_valid = 1'b0; trail_valid = 1'b0;
        check("R7", "same-cycle orphan", 64'(fault), 64'd1);
        idle(1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule